// File: doc/BRIEF.md
# USB Device Endpoint Handshake Controller

This block decides, for each decoded token that a full-speed device receives, how the addressed endpoint answers. It serves four endpoints by default. For every SETUP, OUT or IN token it looks at that endpoint's control byte. The endpoint then does one of four things: it stays silent, answers NAK, answers STALL, or completes the transfer. Completion means an ACK for OUT/SETUP or a data packet for IN. The outcome is kept in per-endpoint status and logging registers and in a shared interrupt register.

Upstream logic delivers decoded tokens and data-phase strobes. The strobes are good packet, bad CRC, the received data toggle, and host ACK. Downstream, a packet transmitter takes a one-cycle send request with a kind code and, for data, the DATA0/DATA1 choice. Software works through a small register bus. Endpoint `e` owns addresses `4*e + 0..3`: control, status, completed-type log and NAK-type log. The interrupt register sits at address `4*NUM_EP`.

Top module: `usb_ep_handshake`

## Requirements
- R1: An endpoint whose control enable bit (bit0) is 0 sends nothing, even when its ready bit (bit1) is 1; no interrupt is raised and its status stays 0.
- R2: An enabled endpoint that is not ready answers the data phase with NAK (tx_kind 1). It sets status bit3 and interrupt bit1, and writes the token type into its NAK-type register (offset 3). Token codes: 0 SETUP, 1 IN, 2 OUT.
- R3: An enabled, ready, non-isochronous endpoint answers a good OUT/SETUP packet with ACK (tx_kind 0). It sets interrupt bit0, logs the token type at offset 2, and copies the received data toggle into status bit2.
- R4: With control bit3 (force-STALL) also set, a good OUT/SETUP packet is answered with STALL (tx_kind 2). Status bit1 is set and no completion interrupt is raised.
- R5: With control bit4 (isochronous) set, a good OUT packet completes with no handshake sent. Interrupt bit0 is still set and the type is still logged.
- R6: An IN token to an enabled, ready endpoint sends data (tx_kind 3) with tx_seq equal to control bit2, and status bit2 records it. A following host ACK sets status bit4 and interrupt bit0, and logs type 1.
- R7: An OUT/SETUP packet with a bad CRC gets no handshake. Only status bit0 and interrupt bit2 are set.
- R8: A new token clears the addressed endpoint's status register before recording its own result; other endpoints' status is untouched.
- R9: Writing 1 to an interrupt bit clears it and writing 0 leaves it; the irq output is high while any bit is set.
- R10: Control registers read back what was written. Status and log registers ignore bus writes. All reset to 0.
- R11: Each send request is a single-cycle pulse, one per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | One-cycle strobe: a token for this device was decoded |
| tok_ep | input | EPW | Endpoint number of the token |
| tok_kind | input | 2 | Token type: 0 SETUP, 1 IN, 2 OUT |
| pkt_ok | input | 1 | Data packet after OUT/SETUP received with good CRC |
| pkt_bad | input | 1 | Data packet after OUT/SETUP received with bad CRC |
| pkt_seq | input | 1 | Data toggle of the received packet (1 = DATA1) |
| host_ack | input | 1 | Host ACK received after IN data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_req | output | 1 | One-cycle request to the packet transmitter |
| tx_kind | output | 2 | 0 ACK, 1 NAK, 2 STALL, 3 DATA |
| tx_seq | output | 1 | Data toggle for a DATA send |
| irq | output | 1 | High while any interrupt bit is set |

## Verification
The assertions assume a well-ordered token stream. No token arrives in the cycle right after a send request. Data-phase strobes come only after the token they belong to. pkt_ok and pkt_bad are never high together. The directed tasks keep to this by issuing each token, packet and ACK as an isolated one-cycle strobe. Between strobes they read back or clear registers, so no send request is ever followed directly by another token.

// File: rtl/usbep_pkg.sv
// Package: shared encodings for the endpoint handshake controller.
// Assumes four registers per endpoint, so an address splits into
// endpoint index (upper bits) and register offset (two low bits).
package usbep_pkg;

    localparam int REGS_PER_EP = 4;

    // register offsets inside an endpoint window
    localparam logic [1:0] OFF_CTRL  = 2'd0;
    localparam logic [1:0] OFF_STAT  = 2'd1;
    localparam logic [1:0] OFF_TTYPE = 2'd2;
    localparam logic [1:0] OFF_NTYPE = 2'd3;

    // control bit positions
    localparam int C_EN    = 0;
    localparam int C_RDY   = 1;
    localparam int C_SEQ   = 2;
    localparam int C_STALL = 3;
    localparam int C_ISO   = 4;

    // status bit positions
    localparam int S_ERR   = 0;
    localparam int S_STALL = 1;
    localparam int S_SEQ   = 2;
    localparam int S_NAK   = 3;
    localparam int S_ACK   = 4;

    // interrupt bit positions
    localparam int I_DONE = 0;
    localparam int I_NAK  = 1;
    localparam int I_ERR  = 2;
    localparam int IRQ_W  = 3;

    typedef enum logic [1:0] {
        TOK_SETUP = 2'd0,
        TOK_IN    = 2'd1,
        TOK_OUT   = 2'd2
    } tok_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_DATA  = 2'd3
    } hs_e;

    // one-cycle update request from the responder to the registers
    typedef struct packed {
        logic       clr;      // new token: wipe status first
        logic       err;      // bad CRC seen
        logic       stall;    // STALL sent
        logic       nak;      // NAK sent
        logic       ack;      // host ACK received
        logic       seq_wr;   // write status data toggle
        logic       seq;      // value for the toggle
        logic       done;     // transaction completed, log type
        logic [1:0] kind;     // token type to log
    } ev_t;

endpackage

// File: rtl/usbep_resp.sv
// Responder: per-token state machine that chooses the endpoint's answer.
// Assumes one token is in flight at a time; a new token aborts any wait.
// Event outputs are combinational; send requests are registered.
module usbep_resp
    import usbep_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW   = $clog2(NUM_EP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tok_valid,
    input  logic [EPW-1:0]        tok_ep,
    input  logic [1:0]            tok_kind,
    input  logic                  pkt_ok,
    input  logic                  pkt_bad,
    input  logic                  pkt_seq,
    input  logic                  host_ack,
    input  logic [NUM_EP*8-1:0]   ctrl_flat,
    output logic [EPW-1:0]        ev_ep,
    output ev_t                   ev,
    output logic                  tx_req,
    output logic [1:0]            tx_kind,
    output logic                  tx_seq
);

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT_PKT, ST_WAIT_ACK} st_e;

    st_e            st_q, st_n;
    logic [EPW-1:0] ep_q, ep_n;
    logic [1:0]     kind_q, kind_n;
    logic [7:0]     ctrl_sel;
    logic           send_n, seq_n;
    hs_e            hs_n;

    // Pick the control byte of the endpoint being served.
    always_comb begin
        ctrl_sel = ctrl_flat[(tok_valid ? tok_ep : ep_q)*8 +: 8];
    end

    // Decide the answer and the register updates for this cycle.
    always_comb begin
        st_n   = st_q;
        ep_n   = ep_q;
        kind_n = kind_q;
        ev     = '0;
        ev_ep  = ep_q;
        send_n = 1'b0;
        hs_n   = HS_ACK;
        seq_n  = 1'b0;
        if (tok_valid) begin
            ev_ep   = tok_ep;
            ep_n    = tok_ep;
            kind_n  = tok_kind;
            ev.clr  = 1'b1;
            ev.kind = tok_kind;
            st_n    = ST_IDLE;
            if (tok_kind == TOK_IN) begin
                if (!ctrl_sel[C_EN]) begin
                    st_n = ST_IDLE;
                end else if (!ctrl_sel[C_RDY]) begin
                    send_n = 1'b1;
                    hs_n   = HS_NAK;
                    ev.nak = 1'b1;
                end else if (ctrl_sel[C_STALL]) begin
                    send_n   = 1'b1;
                    hs_n     = HS_STALL;
                    ev.stall = 1'b1;
                end else begin
                    send_n    = 1'b1;
                    hs_n      = HS_DATA;
                    seq_n     = ctrl_sel[C_SEQ];
                    ev.seq_wr = 1'b1;
                    ev.seq    = ctrl_sel[C_SEQ];
                    if (ctrl_sel[C_ISO]) ev.done = 1'b1;
                    else                 st_n    = ST_WAIT_ACK;
                end
            end else begin
                st_n = ST_WAIT_PKT;
            end
        end else begin
            ev.kind = kind_q;
            unique case (st_q)
                ST_WAIT_PKT: begin
                    if (pkt_bad) begin
                        ev.err = 1'b1;
                        st_n   = ST_IDLE;
                    end else if (pkt_ok) begin
                        st_n = ST_IDLE;
                        if (!ctrl_sel[C_EN]) begin
                            st_n = ST_IDLE;
                        end else if (!ctrl_sel[C_RDY]) begin
                            send_n = 1'b1;
                            hs_n   = HS_NAK;
                            ev.nak = 1'b1;
                        end else if (ctrl_sel[C_STALL]) begin
                            send_n   = 1'b1;
                            hs_n     = HS_STALL;
                            ev.stall = 1'b1;
                        end else begin
                            ev.seq_wr = 1'b1;
                            ev.seq    = pkt_seq;
                            ev.done   = 1'b1;
                            send_n    = !ctrl_sel[C_ISO];
                            hs_n      = HS_ACK;
                        end
                    end
                end
                ST_WAIT_ACK: begin
                    if (host_ack) begin
                        ev.ack  = 1'b1;
                        ev.done = 1'b1;
                        st_n    = ST_IDLE;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // Hold the transaction state and register the transmitter request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            ep_q    <= '0;
            kind_q  <= '0;
            tx_req  <= 1'b0;
            tx_kind <= '0;
            tx_seq  <= 1'b0;
        end else begin
            st_q    <= st_n;
            ep_q    <= ep_n;
            kind_q  <= kind_n;
            tx_req  <= send_n;
            tx_kind <= hs_n;
            tx_seq  <= seq_n;
        end
    end

endmodule

// File: rtl/usbep_epregs.sv
// Endpoint register bank: control, status and two type logs per endpoint.
// Control is bus-writable; status and logs change only through responder
// events. Read is a combinational mux over the endpoint windows.
module usbep_epregs
    import usbep_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW   = $clog2(NUM_EP),
    localparam int AW    = $clog2(NUM_EP*REGS_PER_EP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic [EPW-1:0]      ev_ep,
    input  ev_t                 ev,
    output logic [NUM_EP*8-1:0] ctrl_flat,
    output logic [7:0]          ep_rdata
);

    logic [7:0] ctrl_a  [NUM_EP];
    logic [7:0] stat_a  [NUM_EP];
    logic [7:0] ttype_a [NUM_EP];
    logic [7:0] ntype_a [NUM_EP];

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        localparam logic [AW-1:0] BASE = AW'(g*REGS_PER_EP);
        logic [7:0] ctrl_r, stat_r, ttype_r, ntype_r, stat_n;
        logic       hit;

        assign hit = (ev_ep == EPW'(g));

        // Next status: optional wipe, then OR in the reported results.
        always_comb begin
            stat_n = ev.clr ? 8'h00 : stat_r;
            if (ev.err)    stat_n[S_ERR]   = 1'b1;
            if (ev.stall)  stat_n[S_STALL] = 1'b1;
            if (ev.nak)    stat_n[S_NAK]   = 1'b1;
            if (ev.ack)    stat_n[S_ACK]   = 1'b1;
            if (ev.seq_wr) stat_n[S_SEQ]   = ev.seq;
        end

        // Update this endpoint's four registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_r  <= '0;
                stat_r  <= '0;
                ttype_r <= '0;
                ntype_r <= '0;
            end else begin
                if (reg_wr && reg_addr == BASE + AW'(OFF_CTRL)) ctrl_r <= reg_wdata;
                if (hit) begin
                    stat_r <= stat_n;
                    if (ev.done) ttype_r <= {6'b0, ev.kind};
                    if (ev.nak)  ntype_r <= {6'b0, ev.kind};
                end
            end
        end

        assign ctrl_a[g]             = ctrl_r;
        assign stat_a[g]             = stat_r;
        assign ttype_a[g]            = ttype_r;
        assign ntype_a[g]            = ntype_r;
        assign ctrl_flat[g*8 +: 8]   = ctrl_r;
    end

    // Select the addressed register; unmapped addresses read 0.
    always_comb begin
        ep_rdata = 8'h00;
        for (int e = 0; e < NUM_EP; e++) begin
            if (reg_addr[AW-1:2] == (AW-2)'(e)) begin
                unique case (reg_addr[1:0])
                    OFF_CTRL:  ep_rdata = ctrl_a[e];
                    OFF_STAT:  ep_rdata = stat_a[e];
                    OFF_TTYPE: ep_rdata = ttype_a[e];
                    default:   ep_rdata = ntype_a[e];
                endcase
            end
        end
    end

endmodule

// File: rtl/usbep_irq.sv
// Interrupt register: set by responder events, cleared by writing ones.
// A set and a clear of the same bit in one cycle leaves the bit set.
module usbep_irq
    import usbep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_wr,
    input  logic [IRQ_W-1:0] clr_mask,
    input  ev_t              ev,
    output logic [IRQ_W-1:0] flags
);

    logic [IRQ_W-1:0] set_v;

    // Map responder events onto interrupt bits.
    always_comb begin
        set_v         = '0;
        set_v[I_DONE] = ev.done;
        set_v[I_NAK]  = ev.nak;
        set_v[I_ERR]  = ev.err;
    end

    // Apply write-one-to-clear, then new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~(clr_wr ? clr_mask : '0)) | set_v;
    end

endmodule

// File: rtl/usb_ep_handshake.sv
// Top: endpoint handshake controller for a full-speed device.
// Wires the responder, the endpoint register bank and the interrupt
// register, and places the interrupt register after the endpoint windows.
// Assumes NUM_EP is a power of two, at least 2.
module usb_ep_handshake
    import usbep_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW   = $clog2(NUM_EP),
    localparam int AW    = $clog2(NUM_EP*REGS_PER_EP + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tok_valid,
    input  logic [EPW-1:0] tok_ep,
    input  logic [1:0]     tok_kind,
    input  logic           pkt_ok,
    input  logic           pkt_bad,
    input  logic           pkt_seq,
    input  logic           host_ack,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    output logic           tx_req,
    output logic [1:0]     tx_kind,
    output logic           tx_seq,
    output logic           irq
);

    localparam logic [AW-1:0] IRQ_ADDR = AW'(NUM_EP*REGS_PER_EP);

    ev_t                 ev;
    logic [EPW-1:0]      ev_ep;
    logic [NUM_EP*8-1:0] ctrl_flat;
    logic [7:0]          ep_rdata;
    logic [IRQ_W-1:0]    flags;

    usbep_resp #(.NUM_EP(NUM_EP)) resp_i (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_kind(tok_kind),
        .pkt_ok(pkt_ok), .pkt_bad(pkt_bad), .pkt_seq(pkt_seq),
        .host_ack(host_ack), .ctrl_flat(ctrl_flat),
        .ev_ep(ev_ep), .ev(ev),
        .tx_req(tx_req), .tx_kind(tx_kind), .tx_seq(tx_seq)
    );

    usbep_epregs #(.NUM_EP(NUM_EP)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ev_ep(ev_ep), .ev(ev),
        .ctrl_flat(ctrl_flat), .ep_rdata(ep_rdata)
    );

    usbep_irq irq_i (
        .clk(clk), .rst_n(rst_n),
        .clr_wr(reg_wr && reg_addr == IRQ_ADDR),
        .clr_mask(reg_wdata[IRQ_W-1:0]),
        .ev(ev), .flags(flags)
    );

    // Read mux between the interrupt register and the endpoint bank.
    always_comb begin
        reg_rdata = (reg_addr == IRQ_ADDR) ? {{(8-IRQ_W){1'b0}}, flags} : ep_rdata;
    end

    assign irq = |flags;

endmodule

// File: rtl/usb_ep_handshake_chk.sv
// Checker: temporal properties on the controller's ports, bound to the top.
// Assumes a well-ordered token stream (see the brief).
module usb_ep_handshake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tok_valid,
    input logic [1:0] tok_kind,
    input logic       pkt_ok,
    input logic       pkt_bad,
    input logic       tx_req,
    input logic [1:0] tx_kind,
    input logic       irq
);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    a_r3_ack_follows_packet: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_kind == 2'd0) |-> $past(pkt_ok));

    a_r6_data_follows_in: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_kind == 2'd3) |-> $past(tok_valid && tok_kind == 2'd1));

    a_r7_bad_crc_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_bad && !tok_valid) |=> !tx_req);

    a_r2_nak_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_kind == 2'd1) |-> irq);

endmodule

bind usb_ep_handshake usb_ep_handshake_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .pkt_ok(pkt_ok), .pkt_bad(pkt_bad), .tx_req(tx_req),
    .tx_kind(tx_kind), .irq(irq)
);

// File: tb/usb_ep_handshake_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module usb_ep_handshake_tb_top;

    localparam int AW = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_ep = '0;
    logic [1:0] tok_kind = '0;
    logic       pkt_ok = 1'b0, pkt_bad = 1'b0, pkt_seq = 1'b0, host_ack = 1'b0;
    logic       reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       tx_req, tx_seq, irq;
    logic [1:0] tx_kind;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [7:0] rd;

    usb_ep_handshake dut_i (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
        .tok_kind(tok_kind), .pkt_ok(pkt_ok), .pkt_bad(pkt_bad),
        .pkt_seq(pkt_seq), .host_ack(host_ack), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_req(tx_req), .tx_kind(tx_kind), .tx_seq(tx_seq), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic token(input int ep, input int kind);
        @(negedge clk);
        tok_valid = 1'b1; tok_ep = 2'(ep); tok_kind = 2'(kind);
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic packet(input bit ok, input bit bad, input bit seq);
        @(negedge clk);
        pkt_ok = ok; pkt_bad = bad; pkt_seq = seq;
        @(negedge clk);
        pkt_ok = 1'b0; pkt_bad = 1'b0;
    endtask

    task automatic hack();
        @(negedge clk);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 tx_req after reset", tx_req, 0);
        bus_rd(16, rd); chk("R10 irq reg reset", rd, 0);
        bus_rd(0, rd);  chk("R10 ctrl reset", rd, 0);
        chk("R9 irq pin reset", irq, 0);
    endtask

    task automatic t_addr();
        bus_wr(8, 8'h13);
        bus_rd(8, rd);  chk("R10 ep2 ctrl readback", rd, 8'h13);
        bus_rd(4, rd);  chk("R10 ep1 ctrl untouched", rd, 0);
        bus_wr(9, 8'hFF);
        bus_rd(9, rd);  chk("R10 status write ignored", rd, 0);
    endtask

    task automatic t_disabled();
        bus_wr(4, 8'h02);
        token(1, 2);     chk("R1 no send on token", tx_req, 0);
        packet(1, 0, 0); chk("R1 no send on packet", tx_req, 0);
        bus_rd(16, rd);  chk("R1 no interrupt", rd, 0);
        bus_rd(5, rd);   chk("R1 status stays 0", rd, 0);
    endtask

    task automatic t_nak();
        bus_wr(0, 8'h01);
        token(0, 1);
        chk("R2 nak request", tx_req, 1);
        chk("R2 nak kind", tx_kind, 1);
        @(negedge clk);  chk("R11 request is one pulse", tx_req, 0);
        bus_rd(1, rd);   chk("R2 nak status bit3", rd, 8'h08);
        bus_rd(16, rd);  chk("R2 nak interrupt bit1", rd, 8'h02);
        bus_rd(3, rd);   chk("R2 nak type IN", rd, 1);
        bus_wr(16, 8'h02);
        bus_rd(16, rd);  chk("R9 write one clears", rd, 0);
    endtask

    task automatic t_ack();
        bus_wr(12, 8'h03);
        token(3, 0);     chk("R3 no send before packet", tx_req, 0);
        packet(1, 0, 1);
        chk("R3 ack request", tx_req, 1);
        chk("R3 ack kind", tx_kind, 0);
        bus_rd(13, rd);  chk("R3 status toggle bit2", rd, 8'h04);
        bus_rd(16, rd);  chk("R3 done interrupt", rd, 8'h01);
        bus_rd(14, rd);  chk("R3 type SETUP", rd, 0);
        bus_wr(16, 8'h07);
    endtask

    task automatic t_stall();
        bus_wr(12, 8'h0B);
        token(3, 2);
        bus_rd(13, rd);  chk("R8 status wiped by token", rd, 0);
        packet(1, 0, 0);
        chk("R4 stall request", tx_req, 1);
        chk("R4 stall kind", tx_kind, 2);
        bus_rd(13, rd);  chk("R4 stall status bit1", rd, 8'h02);
        bus_rd(16, rd);  chk("R4 no done interrupt", rd, 0);
    endtask

    task automatic t_iso();
        token(2, 2);
        packet(1, 0, 1); chk("R5 no handshake", tx_req, 0);
        @(negedge clk);  chk("R5 still no handshake", tx_req, 0);
        bus_rd(16, rd);  chk("R5 done interrupt", rd, 8'h01);
        bus_rd(10, rd);  chk("R5 type OUT", rd, 2);
        bus_rd(9, rd);   chk("R5 status toggle", rd, 8'h04);
        bus_wr(16, 8'h07);
    endtask

    task automatic t_in();
        bus_wr(4, 8'h07);
        token(1, 1);
        chk("R6 data request", tx_req, 1);
        chk("R6 data kind", tx_kind, 3);
        chk("R6 DATA1 selected", tx_seq, 1);
        bus_rd(5, rd);   chk("R6 status toggle before ack", rd, 8'h04);
        bus_rd(16, rd);  chk("R6 no done before ack", rd, 0);
        hack();
        bus_rd(5, rd);   chk("R6 ack status bit4", rd, 8'h14);
        bus_rd(16, rd);  chk("R6 done after ack", rd, 8'h01);
        bus_rd(6, rd);   chk("R6 type IN", rd, 1);
        bus_wr(16, 8'h07);
        bus_wr(4, 8'h03);
        token(1, 1);     chk("R6 DATA0 selected", tx_seq, 0);
        hack();
        bus_wr(16, 8'h07);
    endtask

    task automatic t_crc();
        bus_wr(12, 8'h03);
        token(3, 2);
        packet(0, 1, 0); chk("R7 no handshake on bad CRC", tx_req, 0);
        bus_rd(13, rd);  chk("R7 error status only", rd, 8'h01);
        bus_rd(16, rd);  chk("R7 error interrupt only", rd, 8'h04);
        bus_rd(5, rd);   chk("R8 other endpoint kept", rd, 8'h10);
    endtask

    task automatic t_w1c();
        token(3, 2);
        packet(1, 0, 0);
        bus_rd(16, rd);  chk("R9 two flags pending", rd, 8'h05);
        chk("R9 irq pin high", irq, 1);
        bus_wr(16, 8'h01);
        bus_rd(16, rd);  chk("R9 zero bits kept", rd, 8'h04);
        bus_wr(16, 8'h04);
        bus_rd(16, rd);  chk("R9 all cleared", rd, 0);
        chk("R9 irq pin low", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_disabled();
        t_nak();
        t_ack();
        t_stall();
        t_iso();
        t_in();
        t_crc();
        t_w1c();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule